// File: doc/BRIEF.md
# I2C Word-Register Slave

This block is a slave on a two-wire I2C bus. It lets a host microcontroller write and read a bank of 16-bit registers that sit outside the block. The block oversamples SCL and SDA with the system clock and detects START and STOP conditions. It answers only to the 7-bit device address 0011010. The first byte of a write sets an 8-bit register pointer. Each following pair of bytes is one word, most significant byte first, and the pointer advances by one after every complete pair. A read is a pointer-setting write followed by a repeated START with R/W = 1. The slave then returns the addressed words in the same byte order, and the pointer again advances once per pair.

The register file itself is outside the block. The block presents the pointer on `reg_addr` and pulses `reg_wr_en` for one cycle with the assembled word on `reg_wr_data`. It samples `reg_rd_data`, which the file must drive combinationally from `reg_addr`. SDA is open drain: `sda_oe` high means the pad pulls the line low.

The controller has thirteen states:
- ST_IDLE waits for START.
- ST_DEV shifts in the address byte. It moves to ST_DEV_ACK on a match or to ST_IGNORE on a miss.
- ST_DEV_ACK moves to ST_PTR for a write or ST_RD_LOAD for a read.
- ST_PTR takes the pointer and moves to ST_PTR_ACK, then ST_WR_MSB.
- The write loop is ST_WR_MSB → ST_WR_MSB_ACK → ST_WR_LSB → ST_WR_LSB_ACK. The last of these strobes the write and returns to ST_WR_MSB.
- The read loop is ST_RD_LOAD → ST_RD_BYTE → ST_RD_ACK. ST_RD_ACK goes back to ST_RD_BYTE for the low byte, or to ST_RD_LOAD for the next word. On a host not-acknowledge it goes to ST_IGNORE.
- From any state, STOP goes to ST_IDLE and START goes to ST_DEV.

Top module: `i2c_word_slave`

## Requirements
- R1: After reset `sda_oe` is 0, `reg_wr_en` is 0 and `reg_addr` is 0.
- R2: An address byte whose upper seven bits are 0011010 is acknowledged. The acknowledge is SDA held low during the ninth SCL pulse, for both R/W = 0 (byte 0x34) and R/W = 1 (byte 0x35).
- R3: An address byte with any other upper seven bits is not acknowledged. Later bytes are neither acknowledged nor written until the next START or STOP.
- R4: In a write, the byte after the address is acknowledged and becomes the pointer on `reg_addr`.
- R5: Each data byte of a write is acknowledged. After the ninth clock of the second byte of a pair, `reg_wr_en` pulses for exactly one cycle. During that cycle `reg_wr_data` holds {first byte, second byte} and `reg_addr` holds the current pointer.
- R6: The cycle after each write strobe, the pointer is one higher, wrapping from 0xFF to 0x00.
- R7: A STOP after only the first byte of a pair writes nothing, and the pointer stays where it was.
- R8: In a read, the slave sends the word at the pointer, high byte first, each byte MSB first.
- R9: In a read, the pointer advances by one after every complete pair, so the next pair returns the next register.
- R10: A host not-acknowledge ends the read. The slave releases SDA, so further clocks read as all ones, and the pointer does not advance for a pair left unfinished.
- R11: The slave changes its SDA drive only while SCL is low.
- R12: A STOP leaves the slave not driving SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| reg_addr | output | 8 | Register pointer |
| reg_wr_en | output | 1 | One-cycle register write strobe |
| reg_wr_data | output | 16 | Word to write |
| reg_rd_data | input | 16 | Word at `reg_addr`, driven combinationally |

## Verification
Single-word and three-word writes use different bit patterns, so a swapped byte order or a pointer that moves per byte shows up as a wrong word at a wrong address. A burst starting at 0xFE separates a correct wrap from a stuck or overflowing pointer. A STOP after a lone high byte shows whether a partial word ever reaches the register file. Reads ending in a host not-acknowledge, either after a full pair or after only the high byte, show whether the pointer advances per pair and whether the slave lets go of SDA. A mismatched address followed by a further byte separates "ignore until the next condition" from a slave that re-arms on the next byte.

// File: rtl/i2c_word_pkg.sv
package i2c_word_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WR_MSB,
        ST_WR_MSB_ACK,
        ST_WR_LSB,
        ST_WR_LSB_ACK,
        ST_RD_LOAD,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } slv_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;

    // Both lines pass through the same depth so their relative order is kept.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_d    <= scl_pipe[STAGES-1];
            sda_d    <= sda_pipe[STAGES-1];
        end
    end

    always_comb begin
        scl_s     = scl_pipe[STAGES-1];
        sda_s     = sda_pipe[STAGES-1];
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        // An SDA edge while SCL stays high marks a bus condition.
        start_evt = scl_s & scl_d & sda_d & ~sda_s;
        stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/i2c_byte_shifter.sv
module i2c_byte_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] data_o,
    output logic         msb_o
);

    logic [W-1:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (load) begin
            sr_q <= load_val;
        end else if (shift) begin
            sr_q <= {sr_q[W-2:0], shift_in};
        end
    end

    always_comb begin
        data_o = sr_q;
        msb_o  = sr_q[W-1];
    end

endmodule

// File: rtl/i2c_word_ctrl.sv
module i2c_word_ctrl
    import i2c_word_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'b0011010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [BYTE_W-1:0] sr_data,
    input  logic              sr_msb,
    output logic              sr_load,
    output logic [BYTE_W-1:0] sr_load_val,
    output logic              sr_shift,
    output logic              sr_shift_in,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [WORD_W-1:0] reg_wr_data,
    input  logic [WORD_W-1:0] reg_rd_data
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    slv_state_t        state_q, state_d;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              byte_full;
    logic              addr_hit;
    logic              rx_state;
    logic              cnt_state;
    logic              rw_q;
    logic              host_ack_q;
    logic              rd_lsb_q;
    logic [BYTE_W-1:0] msb_q;
    logic [WORD_W-1:0] word_q;
    logic [BYTE_W-1:0] ptr_q;
    logic              wr_en_q;
    logic [WORD_W-1:0] wr_data_q;

    always_comb begin
        byte_full = (bit_cnt_q == FULL_CNT);
        addr_hit  = (sr_data[BYTE_W-1:1] == DEV_ADDR);
        rx_state  = (state_q == ST_DEV) || (state_q == ST_PTR) ||
                    (state_q == ST_WR_MSB) || (state_q == ST_WR_LSB);
        cnt_state = rx_state || (state_q == ST_RD_BYTE);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        if (stop_evt) begin
            state_d = ST_IDLE;
        end else if (start_evt) begin
            state_d = ST_DEV;
        end else begin
            unique case (state_q)
                ST_IDLE:       state_d = ST_IDLE;
                ST_DEV:        if (scl_fall && byte_full) state_d = addr_hit ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:    if (scl_fall) state_d = rw_q ? ST_RD_LOAD : ST_PTR;
                ST_PTR:        if (scl_fall && byte_full) state_d = ST_PTR_ACK;
                ST_PTR_ACK:    if (scl_fall) state_d = ST_WR_MSB;
                ST_WR_MSB:     if (scl_fall && byte_full) state_d = ST_WR_MSB_ACK;
                ST_WR_MSB_ACK: if (scl_fall) state_d = ST_WR_LSB;
                ST_WR_LSB:     if (scl_fall && byte_full) state_d = ST_WR_LSB_ACK;
                ST_WR_LSB_ACK: if (scl_fall) state_d = ST_WR_MSB;
                ST_RD_LOAD:    state_d = ST_RD_BYTE;
                ST_RD_BYTE:    if (scl_fall && byte_full) state_d = ST_RD_ACK;
                ST_RD_ACK: begin
                    if (scl_fall) begin
                        if (!host_ack_q)   state_d = ST_IGNORE;
                        else if (rd_lsb_q) state_d = ST_RD_LOAD;
                        else               state_d = ST_RD_BYTE;
                    end
                end
                ST_IGNORE:     state_d = ST_IGNORE;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // Bit counter: cleared on every state change, counts SCL rises inside a byte
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
        end else if ((state_d != state_q) || start_evt) begin
            bit_cnt_q <= '0;
        end else if (cnt_state && scl_rise && !byte_full) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Shifter control: receive on SCL rise, transmit on SCL fall
    always_comb begin
        sr_load     = 1'b0;
        sr_load_val = '0;
        sr_shift    = 1'b0;
        sr_shift_in = 1'b0;
        if (state_q == ST_RD_LOAD) begin
            sr_load     = 1'b1;
            sr_load_val = reg_rd_data[WORD_W-1:BYTE_W];
        end else if ((state_q == ST_RD_ACK) && scl_fall && host_ack_q && !rd_lsb_q) begin
            sr_load     = 1'b1;
            sr_load_val = word_q[BYTE_W-1:0];
        end else if (rx_state && scl_rise && !byte_full) begin
            sr_shift    = 1'b1;
            sr_shift_in = sda_s;
        end else if ((state_q == ST_RD_BYTE) && scl_fall && !byte_full && (bit_cnt_q != '0)) begin
            sr_shift    = 1'b1;
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q       <= 1'b0;
            host_ack_q <= 1'b0;
            rd_lsb_q   <= 1'b0;
            msb_q      <= '0;
            word_q     <= '0;
            ptr_q      <= '0;
            wr_en_q    <= 1'b0;
            wr_data_q  <= '0;
        end else begin
            wr_en_q <= 1'b0;
            if (wr_en_q) begin
                ptr_q <= ptr_q + 1'b1;
            end
            if ((state_q == ST_DEV) && (state_d == ST_DEV_ACK)) begin
                rw_q <= sr_data[0];
            end
            if ((state_q == ST_PTR) && (state_d == ST_PTR_ACK)) begin
                ptr_q <= sr_data;
            end
            if ((state_q == ST_WR_MSB) && (state_d == ST_WR_MSB_ACK)) begin
                msb_q <= sr_data;
            end
            if ((state_q == ST_WR_LSB_ACK) && (state_d == ST_WR_MSB)) begin
                wr_en_q   <= 1'b1;
                wr_data_q <= {msb_q, sr_data};
            end
            if (state_q == ST_RD_LOAD) begin
                word_q   <= reg_rd_data;
                rd_lsb_q <= 1'b0;
            end
            if ((state_q == ST_RD_ACK) && scl_rise) begin
                host_ack_q <= ~sda_s;
            end
            if ((state_q == ST_RD_ACK) && scl_fall && !stop_evt && !start_evt) begin
                if (rd_lsb_q) ptr_q <= ptr_q + 1'b1;
                else          rd_lsb_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_DEV_ACK, ST_PTR_ACK, ST_WR_MSB_ACK, ST_WR_LSB_ACK: sda_oe = 1'b1;
            ST_RD_BYTE: sda_oe = ~sr_msb;
            default:    sda_oe = 1'b0;
        endcase
        reg_addr    = ptr_q;
        reg_wr_en   = wr_en_q;
        reg_wr_data = wr_data_q;
    end

    AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);                                       // R11
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);                                          // R5
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> (reg_addr == $past(reg_addr) + 8'd1));                // R6
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);                                              // R12
    AST_WR_AFTER_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reg_wr_en) |-> ($past(state_q) == ST_WR_LSB_ACK));            // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt_q <= FULL_CNT);                                             // R8

endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
    import i2c_word_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b0011010,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [BYTE_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [WORD_W-1:0] reg_wr_data,
    input  logic [WORD_W-1:0] reg_rd_data
);

    logic              scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic [BYTE_W-1:0] sr_data, sr_load_val;
    logic              sr_msb, sr_load, sr_shift, sr_shift_in;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_raw   (scl_i),
        .sda_raw   (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2c_byte_shifter #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sr_load),
        .load_val (sr_load_val),
        .shift    (sr_shift),
        .shift_in (sr_shift_in),
        .data_o   (sr_data),
        .msb_o    (sr_msb)
    );

    i2c_word_ctrl #(.DEV_ADDR(DEV_ADDR)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_s       (scl_s),
        .sda_s       (sda_s),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_evt   (start_evt),
        .stop_evt    (stop_evt),
        .sr_data     (sr_data),
        .sr_msb      (sr_msb),
        .sr_load     (sr_load),
        .sr_load_val (sr_load_val),
        .sr_shift    (sr_shift),
        .sr_shift_in (sr_shift_in),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

endmodule

// File: tb/sim_i2c_word_slave.sv
module sim_i2c_word_slave;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [7:0]  reg_addr;
    logic        reg_wr_en;
    logic [15:0] reg_wr_data;
    logic [15:0] reg_rd_data;
    logic [15:0] mem [0:255];
    int          wr_cnt = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    int          glitches = 0;
    logic        scl_prev = 1'b1;
    logic        oe_prev = 1'b0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line    = sda_m & ~sda_oe;
    assign reg_rd_data = mem[reg_addr];

    i2c_word_slave u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe      (sda_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data)
    );

    // Bench-side register file fed only from the block's ports
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 16'h0000;
        end else if (reg_wr_en) begin
            mem[reg_addr] <= reg_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    // R11 monitor: drive changes while the line clock is high
    always @(negedge clk) begin
        if (rst_n && scl_m && scl_prev && (sda_oe !== oe_prev)) glitches <= glitches + 1;
        scl_prev <= scl_m;
        oe_prev  <= sda_oe;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait();
            scl_m = 1'b1; qwait(); qwait();
            scl_m = 1'b0; qwait();
        end
        sda_m = 1'b1; qwait();
        scl_m = 1'b1; qwait();
        ack = ~sda_line;
        qwait();
        scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait();
            scl_m = 1'b1; qwait();
            b[i] = sda_line;
            qwait();
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; qwait();
        scl_m = 1'b1; qwait(); qwait();
        scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    task automatic open_write(input logic [7:0] ptr);
        logic a;
        bus_start();
        send_byte(8'h34, a); chk("R2 write address ack", a, 1'b1);
        send_byte(ptr, a);   chk("R4 pointer ack", a, 1'b1);
        chk("R4 pointer loaded", reg_addr, ptr);
    endtask

    task automatic put_word(input logic [15:0] w);
        logic a;
        send_byte(w[15:8], a); chk("R5 high byte ack", a, 1'b1);
        send_byte(w[7:0], a);  chk("R5 low byte ack", a, 1'b1);
    endtask

    task automatic t_reset();
        chk("R1 sda_oe", sda_oe, 1'b0);
        chk("R1 reg_wr_en", reg_wr_en, 1'b0);
        chk("R1 reg_addr", reg_addr, 8'h00);
    endtask

    task automatic t_write_single();
        int n0 = wr_cnt;
        open_write(8'h10);
        put_word(16'hA53C);
        chk("R5 one write", wr_cnt - n0, 1);
        chk("R5 word stored at pointer", mem[8'h10], 16'hA53C);
        chk("R6 pointer after word", reg_addr, 8'h11);
        bus_stop();
        chk("R12 released after stop", sda_oe, 1'b0);
    endtask

    task automatic t_write_wrap();
        int n0 = wr_cnt;
        open_write(8'hFE);
        put_word(16'h1111);
        put_word(16'h2222);
        put_word(16'h3333);
        bus_stop();
        chk("R6 burst writes", wr_cnt - n0, 3);
        chk("R6 word at FE", mem[8'hFE], 16'h1111);
        chk("R6 word at FF", mem[8'hFF], 16'h2222);
        chk("R6 wrapped word at 00", mem[8'h00], 16'h3333);
        chk("R6 pointer after wrap", reg_addr, 8'h01);
    endtask

    task automatic t_partial();
        logic a;
        int n0 = wr_cnt;
        open_write(8'h20);
        put_word(16'h5A5A);
        send_byte(8'hC3, a); chk("R5 lone high byte ack", a, 1'b1);
        bus_stop();
        chk("R7 only the full pair written", wr_cnt - n0, 1);
        chk("R7 partial word dropped", mem[8'h21], 16'h0000);
        chk("R7 pointer not advanced", reg_addr, 8'h21);
        chk("R12 released after partial", sda_oe, 1'b0);
    endtask

    task automatic t_bad_addr();
        logic a;
        int n0 = wr_cnt;
        bus_start();
        send_byte(8'h36, a); chk("R3 foreign address not acked", a, 1'b0);
        send_byte(8'h34, a); chk("R3 later byte ignored", a, 1'b0);
        send_byte(8'h77, a); chk("R3 still ignored", a, 1'b0);
        bus_stop();
        chk("R3 nothing written", wr_cnt - n0, 0);
        chk("R3 pointer untouched", reg_addr, 8'h21);
    endtask

    task automatic t_read_pairs();
        logic a;
        logic [7:0] b;
        open_write(8'h40);
        put_word(16'h1234);
        put_word(16'hBEEF);
        bus_stop();
        open_write(8'h40);
        bus_start();
        send_byte(8'h35, a);  chk("R2 read address ack", a, 1'b1);
        recv_byte(1'b1, b);   chk("R8 first high byte", b, 8'h12);
        recv_byte(1'b1, b);   chk("R8 first low byte", b, 8'h34);
        recv_byte(1'b1, b);   chk("R9 next register high byte", b, 8'hBE);
        recv_byte(1'b0, b);   chk("R9 next register low byte", b, 8'hEF);
        chk("R10 released after nack", sda_oe, 1'b0);
        bus_stop();
        chk("R9 pointer after two pairs", reg_addr, 8'h42);
    endtask

    task automatic t_read_nack_mid();
        logic a;
        logic [7:0] b;
        open_write(8'h41);
        bus_start();
        send_byte(8'h35, a);  chk("R2 read address ack again", a, 1'b1);
        recv_byte(1'b0, b);   chk("R8 high byte before nack", b, 8'hBE);
        recv_byte(1'b1, b);   chk("R10 bus released", b, 8'hFF);
        chk("R10 pointer kept for unfinished pair", reg_addr, 8'h41);
        bus_stop();
        chk("R12 idle after read", sda_oe, 1'b0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_single();
        t_write_wrap();
        t_partial();
        t_bad_addr();
        t_read_pairs();
        t_read_nack_mid();
        chk("R11 drive changes only with SCL low", glitches, 0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule